// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words in the common single-precision layout and returns the 32-bit product. Each operand is broken into its sign, biased exponent and fraction. The result sign is formed separately from the magnitude. The exponents are summed and the bias is removed. Each fraction gets its hidden leading one back, and the two 24-bit significands are multiplied into a 48-bit product. The fraction window is then picked from that product, and the three fields are packed into the output word.

The significand multiply uses a radix-4 recoded array. Its operand-sign controls are tied to unsigned, so it gives a plain 24x24 unsigned product. The fraction is truncated and never rounded. Zeros, subnormals, infinities and NaNs get no special treatment: every operand is decoded as a normal number. An exponent that leaves the 8-bit range wraps silently. An optional output register, on by default, gives one cycle of latency and is cleared by a synchronous active-high reset.

Top module: `fp32_mul_unit`

## Requirements
- R1: Operands and result share one layout: sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0.
- R2: Result bit 31 equals the XOR of operand bits 31.
- R3: The result exponent equals exp_a + exp_b - 127, plus one when normalization steps up, reduced modulo 256.
- R4: Each significand is the operand fraction with a leading 1 placed above bit 22, and the two significands are multiplied as unsigned 24-bit values into a 48-bit product P.
- R5: When P[47] is 1, the result fraction is P[46:24] and the exponent is raised by one. For example, 1.5 x 1.5 gives 0x40100000.
- R6: When P[47] is 0, the result fraction is P[45:23] and the exponent is not raised. For example, 1.0 x 1.0 gives 0x3F800000.
- R7: Product bits below the chosen window are dropped with no rounding. For example, 0x3FBFFFFF x 0x3FBFFFFF gives 0x400FFFFE and not 0x400FFFFF.
- R8: With the output register enabled (the default), the result for operands present at a rising clock edge appears after that edge and holds until the next edge. While rst is high at an edge, the result becomes 0.
- R9: Exponent overflow and underflow wrap with no saturation. 0x7F800000 x 0x7F800000 gives 0x3F800000, and 0x00000000 x 0x00000000 gives 0x40800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset, clears the result register |
| op_a | input | 32 | First floating-point operand |
| op_b | input | 32 | Second floating-point operand |
| result | output | 32 | Packed floating-point product |

## Verification
Every result is due exactly one rising edge after its operands are applied, because the only register on the path is the output stage. The bench changes the operands on the falling edge and reads the result on the following falling edge, so each comparison sees the product of the pair applied half a cycle before that edge. One check reads the output just after new operands are applied and before the next rising edge, to confirm that the previous product still holds. Reset clearing is read while rst is held high, before any product is registered.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;
  parameter int BIAS   = 127;
  parameter int SIG_W  = FRAC_W + 1;
  parameter int WORD_W = 1 + EXP_W + FRAC_W;
  parameter int PROD_W = 2 * SIG_W;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;
endpackage

// File: rtl/fpm_booth_mul.sv
module fpm_booth_mul #(
  parameter int N = 24
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  input  logic           mcand_signed,
  input  logic           mplier_signed,
  output logic [2*N-1:0] prod
);
  localparam int EW  = N + 1;
  localparam int ND  = EW / 2 + 1;
  localparam int PAD = 2 * ND - EW;
  localparam int PW  = 2 * N + 2;

  logic          cand_top;
  logic          plier_top;
  logic [PW-1:0] cand_w;
  logic [2*ND:0] grp_src;
  logic [PW-1:0] pp [ND];
  logic [ND-1:0] neg_v;
  logic [PW-1:0] corr;
  logic [PW-1:0] acc;

  assign cand_top  = mcand_signed & mcand[N-1];
  assign plier_top = mplier_signed & mplier[N-1];
  assign cand_w    = {{(PW-N){cand_top}}, mcand};
  assign grp_src   = {{PAD{plier_top}}, plier_top, mplier, 1'b0};

  for (genvar g = 0; g < ND; g++) begin : g_digit
    logic [2:0]    trip;
    logic          d_one;
    logic          d_two;
    logic [PW-1:0] mag;
    assign trip     = grp_src[2*g+2 -: 3];
    assign d_one    = trip[1] ^ trip[0];
    assign d_two    = (trip == 3'b011) || (trip == 3'b100);
    assign neg_v[g] = trip[2] & ~(trip[1] & trip[0]);
    assign mag      = d_two ? (cand_w << 1) : (d_one ? cand_w : '0);
    assign pp[g]    = (neg_v[g] ? ~mag : mag) << (2 * g);
  end

  always_comb begin
    corr = '0;
    for (int g = 0; g < ND; g++) begin
      corr[2*g] = neg_v[g];
    end
  end

  always_comb begin
    acc = corr;
    for (int g = 0; g < ND; g++) begin
      acc = acc + pp[g];
    end
  end

  assign prod = (2*N)'(acc);
endmodule

// File: rtl/fpm_exp_unit.sv
module fpm_exp_unit #(
  parameter int EW = 8,
  parameter int B  = 127
) (
  input  logic [EW-1:0] exp_a,
  input  logic [EW-1:0] exp_b,
  input  logic          norm_inc,
  output logic [EW-1:0] exp_out
);
  localparam int XW = EW + 2;

  logic [XW-1:0] sum_raw;
  logic [XW-1:0] neg_bias;

  assign sum_raw  = {2'b00, exp_a} + {2'b00, exp_b};
  assign neg_bias = ~XW'(B) + XW'(1);
  assign exp_out  = EW'(sum_raw + neg_bias + XW'(norm_inc));
endmodule

// File: rtl/fpm_norm_unit.sv
module fpm_norm_unit #(
  parameter int SW = 24,
  parameter int FW = 23
) (
  input  logic [2*SW-1:0] prod,
  output logic            step_up,
  output logic [FW-1:0]   frac_out
);
  assign step_up  = prod[2*SW-1];
  assign frac_out = step_up ? FW'(prod >> SW) : FW'(prod >> (SW - 1));
endmodule

// File: rtl/fp32_mul_unit.sv
module fp32_mul_unit
  import fpm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] result
);
  fp_word_t           fa;
  fp_word_t           fb;
  fp_word_t           packed_res;
  logic [SIG_W-1:0]   sig_a;
  logic [SIG_W-1:0]   sig_b;
  logic [PROD_W-1:0]  sig_prod;
  logic               step_up;
  logic [FRAC_W-1:0]  frac_res;
  logic [EXP_W-1:0]   exp_res;

  assign fa    = fp_word_t'(op_a);
  assign fb    = fp_word_t'(op_b);
  assign sig_a = {1'b1, fa.frac};
  assign sig_b = {1'b1, fb.frac};

  fpm_booth_mul #(.N(SIG_W)) u_sig_mul (
    .mcand        (sig_a),
    .mplier       (sig_b),
    .mcand_signed (1'b0),
    .mplier_signed(1'b0),
    .prod         (sig_prod)
  );

  fpm_norm_unit #(.SW(SIG_W), .FW(FRAC_W)) u_norm (
    .prod    (sig_prod),
    .step_up (step_up),
    .frac_out(frac_res)
  );

  fpm_exp_unit #(.EW(EXP_W), .B(BIAS)) u_exp (
    .exp_a   (fa.expo),
    .exp_b   (fb.expo),
    .norm_inc(step_up),
    .exp_out (exp_res)
  );

  assign packed_res.sign = fa.sign ^ fb.sign;
  assign packed_res.expo = exp_res;
  assign packed_res.frac = frac_res;

  if (OUT_REG) begin : g_oreg
    logic [WORD_W-1:0] res_q;
    always_ff @(posedge clk) begin
      if (rst) res_q <= '0;
      else     res_q <= packed_res;
    end
    assign result = res_q;
  end else begin : g_comb
    assign result = packed_res;
  end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk
  import fpm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic [WORD_W-1:0] result
);
  localparam int MSB = WORD_W - 1;
  localparam int EHI = WORD_W - 2;

  logic [WORD_W-1:0] a_d;
  logic [WORD_W-1:0] b_d;
  logic              live;
  logic [EXP_W-1:0]  exp_base;
  logic              fr_zero;
  logic              fr_full;

  if (OUT_REG) begin : g_dly
    logic rst_d;
    always_ff @(posedge clk) begin
      a_d   <= op_a;
      b_d   <= op_b;
      live  <= !rst;
      rst_d <= rst;
    end
    // R8
    reset_clr_chk: assert property (@(posedge clk) rst_d |-> (result == '0))
      else $error("reset_clr_chk");
  end else begin : g_now
    assign a_d  = op_a;
    assign b_d  = op_b;
    assign live = !rst;
  end

  assign exp_base = EXP_W'(a_d[EHI -: EXP_W] + b_d[EHI -: EXP_W] - EXP_W'(BIAS));
  assign fr_zero  = (a_d[FRAC_W-1:0] == '0) && (b_d[FRAC_W-1:0] == '0);
  assign fr_full  = (&a_d[FRAC_W-1:0]) && (&b_d[FRAC_W-1:0]);

  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> (result[MSB] == (a_d[MSB] ^ b_d[MSB])))
    else $error("sign_xor_chk");

  // R6
  unit_frac_chk: assert property (@(posedge clk) disable iff (rst)
    (live && fr_zero) |-> (result[FRAC_W-1:0] == '0))
    else $error("unit_frac_chk");

  // R3
  unit_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (live && fr_zero) |-> (result[EHI -: EXP_W] == exp_base))
    else $error("unit_exp_chk");

  // R5
  full_frac_chk: assert property (@(posedge clk) disable iff (rst)
    (live && fr_full) |-> ((result[FRAC_W-1:0] == {{(FRAC_W-1){1'b1}}, 1'b0})
                           && (result[EHI -: EXP_W] == EXP_W'(exp_base + 1'b1))))
    else $error("full_frac_chk");
endmodule

bind fp32_mul_unit fpm_mul_chk #(.OUT_REG(OUT_REG)) u_mul_chk (
  .clk   (clk),
  .rst   (rst),
  .op_a  (op_a),
  .op_b  (op_b),
  .result(result)
);

// File: tb/test_fp32_mul_unit.sv
module test_fp32_mul_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] result;
  int n_chk  = 0;
  int n_fail = 0;

  fp32_mul_unit i_fp32_mul_unit (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model from R1..R7, R9: normal decoding, truncation, wrap.
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    longint unsigned ma, mb, p;
    int e;
    logic [22:0] f;
    ma = 64'(1 << 23) | 64'(a[22:0]);
    mb = 64'(1 << 23) | 64'(b[22:0]);
    p  = ma * mb;
    e  = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin
      f = p[46:24];
      e = e + 1;
    end else begin
      f = p[45:23];
    end
    return {a[31] ^ b[31], 8'(e), f};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, read one falling edge later (one register).
  task automatic step(input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] exp, input string req);
    op_a = a;
    op_b = b;
    @(negedge clk);
    check(result, exp, req);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    op_a = 32'h3F80_0000;
    op_b = 32'h4000_0000;
    repeat (3) @(negedge clk);
    check(result, 32'h0, "R8 reset clears");
    rst = 1'b0;

    step(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, "R6 1.0x1.0");
    step(32'h4000_0000, 32'h4040_0000, 32'h40C0_0000, "R3 2x3");
    step(32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, "R5 1.5x1.5");
    step(32'hC000_0000, 32'h4040_0000, 32'hC0C0_0000, "R2 -2x3");
    step(32'hBFC0_0000, 32'hBFC0_0000, 32'h4010_0000, "R2 -1.5x-1.5");
    step(32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFE, "R5 full fractions");
    step(32'h3FBF_FFFF, 32'h3FBF_FFFF, 32'h400F_FFFE, "R7 truncation");
    step(32'h3F80_0001, 32'h3F80_0001, 32'h3F80_0002, "R4 hidden one");
    step(32'h7F80_0000, 32'h7F80_0000, 32'h3F80_0000, "R9 overflow wrap");
    step(32'h0000_0000, 32'h0000_0000, 32'h4080_0000, "R9 underflow wrap");

    // R8: new operands must not reach the output before the next rising edge
    op_a = 32'h4040_0000;
    op_b = 32'h4040_0000;
    #1;
    check(result, 32'h4080_0000, "R8 holds until edge");
    @(negedge clk);
    check(result, 32'h4110_0000, "R8 updates after edge");

    // R8: reset mid-run clears the register
    rst = 1'b1;
    @(negedge clk);
    check(result, 32'h0, "R8 reset mid-run");
    rst = 1'b0;

    // R1: assorted words against the model, fields at 31 / 30:23 / 22:0
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      step(ra, rb, ref_mul(ra, rb), "R1 model compare");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule